// File: doc/BRIEF.md
# Accumulator-to-Intermediate Saturator with Flag Merge

This block takes three signed 32-bit accumulator results and narrows each to the signed 16-bit range that later pipeline stages expect. The narrowed results come out sign-extended to 32 bits. At the same time it folds a record of which lanes had to be clamped into a 32-bit status word that arrives with the operands. A single mode input moves the lower clamp limit from the most negative 16-bit value up to zero. This suits consumers that cannot accept negative intermediates, such as colour components.

A second input turns off the status update, and the status word then passes through untouched. The clamps are still applied in that case. Every operand set is presented with a one-cycle strobe. The results appear on the registered outputs one clock later, together with their own strobe, and they hold there until the next operand set.

Top module: `mac_ir_saturator`

## Requirements
- R1: For every lane, an accumulator value of 32768 or more gives a result of 32767, and this counts as saturation of that lane.
- R2: With `floor_zero_i` = 0, an accumulator below -32768 gives -32768 and counts as saturation. A value from -32768 to 32767 inclusive passes through unchanged.
- R3: With `floor_zero_i` = 1, any negative accumulator gives 0 and counts as saturation. A value from 0 to 32767 passes through unchanged.
- R4: When the status update is enabled, saturation of lane 1 sets status bits 24 and 31, and saturation of lane 2 sets status bits 23 and 31.
- R5: When the status update is enabled, saturation of lane 3 sets status bit 22 only. Bit 31 rises only through lane 1, lane 2 or the incoming word.
- R6: The outgoing status word is the incoming word ORed with the bits raised by saturation. No incoming bit is ever cleared.
- R7: With `flag_bypass_i` = 1, `flag_o` equals `flag_i` exactly, while R1 to R3 still apply to the results.
- R8: Results and status are registered. `out_valid_o` is high in exactly the cycle after an `in_valid_i` cycle. The results are sign-extended from bit 15 to 32 bits. All outputs hold their values while no new operand set arrives.
- R9: While `rst_n` is low at a clock edge, the next cycle shows `out_valid_o` low and all results and the status word at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Operand set present this cycle |
| acc1_i | input | 32 | Lane 1 accumulator, signed |
| acc2_i | input | 32 | Lane 2 accumulator, signed |
| acc3_i | input | 32 | Lane 3 accumulator, signed |
| floor_zero_i | input | 1 | 1: lower limit is 0; 0: lower limit is -32768 |
| flag_bypass_i | input | 1 | 1: status word passes unchanged |
| flag_i | input | 32 | Incoming status word |
| out_valid_o | output | 1 | Results valid this cycle |
| ir1_o | output | 32 | Lane 1 result, sign-extended |
| ir2_o | output | 32 | Lane 2 result, sign-extended |
| ir3_o | output | 32 | Lane 3 result, sign-extended |
| flag_o | output | 32 | Outgoing status word |

## Verification
Two lanes can saturate in the same operand set, and both then reach for status bit 31. The bench provokes this with vectors in which lane 3 clips together with lane 1 or lane 2, and with vectors in which lane 3 clips alone. It judges bit 31 as the OR of the incoming bit with the lane 1 and lane 2 saturations only. A second collision is a clamp that falls in the same cycle as the status bypass. There the bench expects the clamped results together with an untouched status word, including incoming words that already carry some of the flag bits.

// File: rtl/mac_sat_pkg.sv
// Package: shared types for the accumulator saturator.
// Assumes: consumers only need to know the direction of a clamp.
package mac_sat_pkg;

    // Outcome of narrowing a single lane.
    typedef enum logic [1:0] {
        SAT_NONE = 2'b00,
        SAT_HIGH = 2'b01,
        SAT_LOW  = 2'b10
    } sat_kind_e;

endpackage

// File: rtl/ir_clamp_lane.sv
// Module: narrows one signed accumulator to the signed IR_W-bit range and
// sign-extends the result to OUT_W bits.
// Assumes: OUT_W > IR_W, IR_W <= ACC_W, and IR_W <= 31.
module ir_clamp_lane
    import mac_sat_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int IR_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic                    floor_zero_i,
    output logic signed [OUT_W-1:0] value_o,
    output sat_kind_e               kind_o
);

    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (IR_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

    logic signed [ACC_W-1:0] narrowed;

    // Choose the limit that applies and note which side clipped.
    always_comb begin
        narrowed = acc_i;
        kind_o   = SAT_NONE;
        if (acc_i > POS_LIM) begin
            narrowed = POS_LIM;
            kind_o   = SAT_HIGH;
        end else if (floor_zero_i && acc_i < 0) begin
            narrowed = '0;
            kind_o   = SAT_LOW;
        end else if (acc_i < NEG_LIM) begin
            narrowed = NEG_LIM;
            kind_o   = SAT_LOW;
        end
    end

    // Sign-extend the narrowed value from its top in-range bit.
    always_comb begin
        value_o = {{(OUT_W - IR_W){narrowed[IR_W-1]}}, narrowed[IR_W-1:0]};
    end

endmodule

// File: rtl/sat_flag_merge.sv
// Module: ORs per-lane saturation bits into a status word, or passes the
// word through untouched when bypass is asserted.
// Assumes: every entry of LANE_POS and SUM_BIT is below FLAG_W.
module sat_flag_merge #(
    parameter int               FLAG_W   = 32,
    parameter int               LANES    = 3,
    parameter logic [LANES*8-1:0] LANE_POS = {8'd22, 8'd23, 8'd24},
    parameter logic [LANES-1:0] SUM_MASK = 3'b011,
    parameter int               SUM_BIT  = 31
) (
    input  logic [LANES-1:0]  sat_i,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic              bypass_i,
    output logic [FLAG_W-1:0] flag_o
);

    logic [FLAG_W-1:0] raised;

    // Collect per-lane bits plus the summary bit for the lanes that feed it.
    always_comb begin
        raised = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sat_i[k]) begin
                raised[LANE_POS[k*8 +: 8]] = 1'b1;
                if (SUM_MASK[k]) begin
                    raised[SUM_BIT] = 1'b1;
                end
            end
        end
    end

    // Merge into the incoming word unless bypassed.
    always_comb begin
        flag_o = bypass_i ? flag_i : (flag_i | raised);
    end

endmodule

// File: rtl/mac_ir_saturator.sv
// Module: top of the accumulator-to-intermediate saturator. Three lanes are
// clamped in parallel, their saturation events merged into the status word,
// and everything registered for one cycle.
// Assumes: in_valid_i is a one-cycle strobe per operand set; outputs hold
// between strobes.
module mac_ir_saturator
    import mac_sat_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int IR_W    = 16,
    parameter int OUT_W   = 32,
    parameter int FLAG_W  = 32,
    parameter int L1_BIT  = 24,
    parameter int L2_BIT  = 23,
    parameter int L3_BIT  = 22,
    parameter int SUM_BIT = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid_i,
    input  logic signed [ACC_W-1:0] acc1_i,
    input  logic signed [ACC_W-1:0] acc2_i,
    input  logic signed [ACC_W-1:0] acc3_i,
    input  logic                    floor_zero_i,
    input  logic                    flag_bypass_i,
    input  logic [FLAG_W-1:0]       flag_i,
    output logic                    out_valid_o,
    output logic signed [OUT_W-1:0] ir1_o,
    output logic signed [OUT_W-1:0] ir2_o,
    output logic signed [OUT_W-1:0] ir3_o,
    output logic [FLAG_W-1:0]       flag_o
);

    localparam int                 LANES    = 3;
    localparam logic [LANES*8-1:0] LANE_POS = {8'(L3_BIT), 8'(L2_BIT), 8'(L1_BIT)};
    localparam logic [LANES-1:0]   SUM_MASK = 3'b011;
    localparam logic signed [OUT_W-1:0] POS_LIM = OUT_W'((1 << (IR_W - 1)) - 1);
    localparam logic signed [OUT_W-1:0] NEG_LIM = ~POS_LIM;

    logic signed [ACC_W-1:0] acc_arr [LANES];
    logic signed [OUT_W-1:0] val_arr [LANES];
    sat_kind_e               kind_arr [LANES];
    logic [LANES-1:0]        sat_vec;
    logic [FLAG_W-1:0]       flag_next;

    // Gather the lane operands into an array for the generate loop.
    always_comb begin
        acc_arr[0] = acc1_i;
        acc_arr[1] = acc2_i;
        acc_arr[2] = acc3_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ir_clamp_lane #(
            .ACC_W (ACC_W),
            .IR_W  (IR_W),
            .OUT_W (OUT_W)
        ) clamp_i (
            .acc_i        (acc_arr[g]),
            .floor_zero_i (floor_zero_i),
            .value_o      (val_arr[g]),
            .kind_o       (kind_arr[g])
        );
        // Reduce a lane's outcome to a single saturation bit.
        assign sat_vec[g] = (kind_arr[g] != SAT_NONE);
    end

    sat_flag_merge #(
        .FLAG_W   (FLAG_W),
        .LANES    (LANES),
        .LANE_POS (LANE_POS),
        .SUM_MASK (SUM_MASK),
        .SUM_BIT  (SUM_BIT)
    ) merge_i (
        .sat_i    (sat_vec),
        .flag_i   (flag_i),
        .bypass_i (flag_bypass_i),
        .flag_o   (flag_next)
    );

    // Output stage: load on a strobe, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            ir1_o       <= '0;
            ir2_o       <= '0;
            ir3_o       <= '0;
            flag_o      <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                ir1_o  <= val_arr[0];
                ir2_o  <= val_arr[1];
                ir3_o  <= val_arr[2];
                flag_o <= flag_next;
            end
        end
    end

    // R1: no result ever exceeds the upper limit.
    a_r1_upper_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (ir1_o <= POS_LIM && ir2_o <= POS_LIM && ir3_o <= POS_LIM));

    // R1: a large lane 1 operand lands exactly on the upper limit.
    a_r1_high_clip: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && ($signed($past(acc1_i)) > $signed(ACC_W'(POS_LIM))) |-> ir1_o == POS_LIM);

    // R2: a very negative lane 2 operand under the wide floor lands on the lower limit.
    a_r2_low_clip: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !$past(floor_zero_i) && ($signed($past(acc2_i)) < $signed(ACC_W'(NEG_LIM)))
        |-> ir2_o == NEG_LIM);

    // R3: with the zero floor no result is negative.
    a_r3_zero_floor: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && $past(floor_zero_i) |-> (!ir1_o[OUT_W-1] && !ir2_o[OUT_W-1] && !ir3_o[OUT_W-1]));

    // R4: a fresh lane 1 flag under update always comes with the summary bit.
    a_r4_l1_summary: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !$past(flag_bypass_i) && flag_o[L1_BIT] && !$past(flag_i[L1_BIT])
        |-> flag_o[SUM_BIT]);

    // R5: the summary bit never rises without lane 1, lane 2 or the incoming word.
    a_r5_no_l3_summary: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !$past(flag_i[SUM_BIT]) && !flag_o[L1_BIT] && !flag_o[L2_BIT]
        |-> !flag_o[SUM_BIT]);

    // R6: incoming status bits are never cleared.
    a_r6_or_merge: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (flag_o & $past(flag_i)) == $past(flag_i));

    // R7: bypass hands the status word through unchanged.
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && $past(flag_bypass_i) |-> flag_o == $past(flag_i));

    // R8: an output strobe always follows an input strobe.
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i));

    // R8: results hold when no operand set arrives.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(ir1_o) && $stable(ir2_o) && $stable(ir3_o) && $stable(flag_o)));

    // R8: results are sign-extended from the top in-range bit.
    a_r8_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (ir3_o[OUT_W-1:IR_W-1] == '0 || ir3_o[OUT_W-1:IR_W-1] == '1));

    // R9: reset clears the output stage.
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid_o && ir1_o == '0 && ir2_o == '0 && ir3_o == '0 && flag_o == '0));

endmodule

// File: tb/mac_ir_saturator_tb_top.sv
`timescale 1ns/1ps
module mac_ir_saturator_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid_i = 1'b0;
    logic signed [31:0] acc1_i = '0;
    logic signed [31:0] acc2_i = '0;
    logic signed [31:0] acc3_i = '0;
    logic               floor_zero_i = 1'b0;
    logic               flag_bypass_i = 1'b0;
    logic [31:0]        flag_i = '0;
    logic               out_valid_o;
    logic signed [31:0] ir1_o, ir2_o, ir3_o;
    logic [31:0]        flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_on   = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int          v1, v2, v3;
        logic [31:0] fl;
        string       req;
    } exp_t;

    exp_t sb[$];
    exp_t last_exp;

    always #2.5 clk = ~clk;

    mac_ir_saturator dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid_i (in_valid_i),
        .acc1_i (acc1_i), .acc2_i (acc2_i), .acc3_i (acc3_i),
        .floor_zero_i (floor_zero_i), .flag_bypass_i (flag_bypass_i),
        .flag_i (flag_i), .out_valid_o (out_valid_o),
        .ir1_o (ir1_o), .ir2_o (ir2_o), .ir3_o (ir3_o), .flag_o (flag_o)
    );

    // Reference clamp taken from R1 to R3.
    function automatic int ref_clamp(input longint v, input bit lz, output bit sat);
        sat = 1'b0;
        if (v >= 32768)          begin sat = 1'b1; return 32767;  end
        if (lz && v < 0)         begin sat = 1'b1; return 0;      end
        if (!lz && v < -32768)   begin sat = 1'b1; return -32768; end
        return int'(v);
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: apply one operand set and push its expected result.
    task automatic send(input int a1, input int a2, input int a3, input bit lz,
                        input bit byp, input logic [31:0] fin, input string req);
        exp_t e;
        bit s1, s2, s3;
        logic [31:0] add;
        @(negedge clk);
        in_valid_i = 1'b1; acc1_i = a1; acc2_i = a2; acc3_i = a3;
        floor_zero_i = lz; flag_bypass_i = byp; flag_i = fin;
        e.v1 = ref_clamp(longint'(a1), lz, s1);
        e.v2 = ref_clamp(longint'(a2), lz, s2);
        e.v3 = ref_clamp(longint'(a3), lz, s3);
        add = '0;
        if (s1) add = add | 32'h8100_0000;   // R4: bits 31 and 24
        if (s2) add = add | 32'h8080_0000;   // R4: bits 31 and 23
        if (s3) add = add | 32'h0040_0000;   // R5: bit 22 only
        e.fl  = byp ? fin : (fin | add);     // R6, R7
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid_i = 1'b0;
        acc1_i = 32'sh7fff_ffff; acc2_i = 32'sh8000_0000; acc3_i = 32'sh1234_5678;
        flag_i = 32'hffff_ffff;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare each output strobe with the scoreboard; check hold otherwise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid_o) begin
                if (sb.size() == 0) begin
                    check("R8", "unexpected out_valid", 1, 0);
                end else begin
                    last_exp = sb.pop_front();
                    check(last_exp.req, "ir1", ir1_o, last_exp.v1);
                    check(last_exp.req, "ir2", ir2_o, last_exp.v2);
                    check(last_exp.req, "ir3", ir3_o, last_exp.v3);
                    check(last_exp.req, "flag", flag_o, last_exp.fl);
                end
            end else begin
                // R8: outputs hold between strobes.
                check("R8", "hold ir1", ir1_o, last_exp.v1);
                check("R8", "hold ir3", ir3_o, last_exp.v3);
                check("R8", "hold flag", flag_o, last_exp.fl);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        last_exp = '{v1: 0, v2: 0, v3: 0, fl: 32'h0, req: "R9"};
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9", "out_valid in reset", out_valid_o, 0);
        check("R9", "ir1 in reset", ir1_o, 0);
        check("R9", "flag in reset", flag_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "out_valid after reset", out_valid_o, 0);
        mon_on = 1'b1;

        // R2: pass-through inside range and the lower rail edges.
        send(1234, -32768, 32767, 1'b0, 1'b0, 32'h0, "R2");
        send(-32769, -1, 0, 1'b0, 1'b0, 32'h0, "R2");
        // R1: upper edges on every lane.
        send(32768, 32'sh7fff_ffff, 40000, 1'b0, 1'b0, 32'h0, "R1");
        send(32'sh8000_0000, 32767, -100, 1'b0, 1'b0, 32'h0, "R1");
        idle(3);
        // R3: zero floor.
        send(-1, 0, 32767, 1'b1, 1'b0, 32'h0, "R3");
        send(32'sh8000_0000, 5, 32768, 1'b1, 1'b0, 32'h0, "R3");
        // R4: lane 1 alone, lane 2 alone.
        send(99999, 0, 0, 1'b0, 1'b0, 32'h0, "R4");
        send(0, -70000, 0, 1'b0, 1'b0, 32'h0, "R4");
        // R5: lane 3 alone, and lane 3 together with lane 1 / lane 2.
        send(0, 0, 70000, 1'b0, 1'b0, 32'h0, "R5");
        send(0, 0, -1, 1'b1, 1'b0, 32'h0, "R5");
        send(-40000, 0, 70000, 1'b0, 1'b0, 32'h0, "R5");
        send(0, 50000, -50000, 1'b0, 1'b0, 32'h0, "R5");
        idle(2);
        // R6: incoming bits kept, including flag positions already set.
        send(0, 0, 0, 1'b0, 1'b0, 32'h8040_0001, "R6");
        send(0, 0, 70000, 1'b0, 1'b0, 32'h0180_0000, "R6");
        send(40000, 1, 2, 1'b0, 1'b0, 32'h7fff_ffff, "R6");
        // R7: bypass with clamps active.
        send(40000, -40000, 40000, 1'b0, 1'b1, 32'h0000_0000, "R7");
        send(-5, 32768, -40000, 1'b1, 1'b1, 32'h1234_5678, "R7");
        idle(4);
        // Mixed vectors with gaps and back-to-back strobes.
        for (int i = 0; i < 300; i++) begin
            int a [3];
            for (int k = 0; k < 3; k++) begin
                case ($urandom_range(0, 3))
                    0: a[k] = int'($urandom);
                    1: a[k] = int'($urandom_range(0, 131071)) - 65536;
                    2: a[k] = int'($urandom_range(0, 8)) + 32764;
                    default: a[k] = -32773 + int'($urandom_range(0, 8));
                endcase
            end
            send(a[0], a[1], a[2], 1'($urandom), 1'($urandom_range(0, 3) == 0),
                 $urandom & 32'h81c0_ffff, "R8");
            if ($urandom_range(0, 4) == 0) idle(1 + int'($urandom_range(0, 2)));
        end
        idle(5);
        check("R8", "scoreboard drained", sb.size(), 0);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule